// File: doc/BRIEF.md
# Quadrature Pulse Event Counter

This block is a 16-bit up/down event counter fed by two pulse trains, phase A and phase B, that run a quarter period apart. It sits beside a larger timer and turns the motion of a rotary or linear encoder into a signed position count. Phase A arrives on the pin that would otherwise carry the timer's output, so no pulse output is generated. Phase B arrives on the ordinary timer input pin. Both pins are asynchronous. Each passes through a two-flop synchroniser, and edges are then found by comparing each synchronised sample with the one before it.

Two decoding styles are available. In gated style the count moves only on edges of phase B, and only while phase A is high. In four-edge style every edge of either phase moves the count by one, and the phase relation sets the direction. An instance parameter either fixes the style or hands the choice to a bit of the mode byte. With two-phase processing switched off, the block acts as a plain event counter on phase B.

Software works through a small register port with four addresses: 0 holds the mode byte, 1 holds control (start and two-phase enable), 2 holds the count and 3 reads back the reload value. Reads have one cycle of latency. A single-cycle wrap strobe marks each pass over the top or the bottom of the range.

Top module: `qpc_counter`

## Requirements
- R1: After reset, count_o is 0, wrap_o is 0, and the mode byte, the control bits and the reload value all read back as 0.
- R2: While the start bit (control bit 0) is 0, input activity never changes the count.
- R3: In gated style, while the synchronised phase A is high, a rising edge of B adds 1 and a falling edge of B subtracts 1. Edges of A, and edges of B while A is low, leave the count unchanged.
- R4: In four-edge style, the state sequence (A,B) = 00→10→11→01→00 adds 1 at each step, and the reverse sequence subtracts 1 at each step.
- R5: In two-phase processing, a clock in which both synchronised phases change leaves the count unchanged.
- R6: Two-phase processing is active only when control bit 1 is 1 and mode bits [5:0] equal 6'b010001. Otherwise each rising edge of B adds 1 and phase A is ignored.
- R7: With STYLE=2, mode bit 7 selects the style (0 gated, 1 four-edge). With STYLE=0 the style is fixed to gated and STYLE=1 fixes it to four-edge, and bit 7 is ignored.
- R8: An increment from 0xFFFF gives 0x0000 and raises wrap_o for exactly one cycle.
- R9: A decrement from 0 gives the reload value when mode bit 6 is 0, or 0xFFFF when it is 1, and raises wrap_o for one cycle in either case.
- R10: A write to address 2 while stopped loads both the count and the reload value. While running, it changes only the reload value.
- R11: rd_data_o shows the register at rd_addr_i (0 mode, 1 control {enable,start}, 2 count, 3 reload) one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a_i | input | 1 | Phase A pulse input, asynchronous |
| phase_b_i | input | 1 | Phase B pulse input, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | CNT_W | Registered read data |
| count_o | output | CNT_W | Current count |
| wrap_o | output | 1 | One-cycle overflow/underflow strobe |

## Verification
Some properties are checked on every cycle. The count holds still while stopped, and it holds still when both phases change in the same clock. In gated style an edge on A alone never moves it. A running count moves by at most one unless a wrap is flagged, and a wrap occurs only from 0 or 0xFFFF. Whether each step goes the right way, and what the wrap loads, can only be shown by the bench's scenarios. Those scenarios cover the gated and four-edge sequences, the reload and no-reload cases, the fallback to plain event counting, the stopped and running count writes, and an instance with its style fixed next to one whose style is set by the mode bit.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;
  localparam logic [1:0] ADDR_RELOAD = 2'd3;

  localparam int MODE_NORELOAD_BIT = 6;
  localparam int MODE_QUAD_BIT     = 7;
  localparam logic [5:0] MODE_TWOPH_PATTERN = 6'b010001;

  localparam int STYLE_GATED  = 0;
  localparam int STYLE_QUAD   = 1;
  localparam int STYLE_SELECT = 2;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic chg_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b0;
          else     sh_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b0;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sh_q[STAGES-1];
  end

  assign level_o = sh_q[STAGES-1];
  assign chg_o   = sh_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic  a_lvl_i,
  input  logic  b_lvl_i,
  input  logic  a_chg_i,
  input  logic  b_chg_i,
  input  logic  twoph_i,
  input  logic  quad_i,
  output step_t step_o
);

  logic only_a;
  logic only_b;

  assign only_a = a_chg_i & ~b_chg_i;
  assign only_b = b_chg_i & ~a_chg_i;

  always_comb begin
    step_o = '0;
    if (!twoph_i) begin
      // plain event counting on B rising edges
      step_o.up = b_chg_i & b_lvl_i;
    end else if (quad_i) begin
      if (only_a) begin
        step_o.up = (a_lvl_i != b_lvl_i);
        step_o.dn = (a_lvl_i == b_lvl_i);
      end else if (only_b) begin
        step_o.up = (b_lvl_i == a_lvl_i);
        step_o.dn = (b_lvl_i != a_lvl_i);
      end
    end else begin
      if (only_b && a_lvl_i) begin
        step_o.up = b_lvl_i;
        step_o.dn = ~b_lvl_i;
      end
    end
  end

endmodule

// File: rtl/qpc_core.sv
module qpc_core
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  step_t            step_i,
  input  logic             ld_cnt_i,
  input  logic             ld_rel_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             norel_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] TOP  = '1;
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rel_q;
  logic             wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= ZERO;
      rel_q  <= ZERO;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (ld_cnt_i) begin
        cnt_q <= wdata_i;
        rel_q <= wdata_i;
      end else begin
        if (ld_rel_i) rel_q <= wdata_i;
        if (run_i && step_i.up) begin
          if (cnt_q == TOP) begin
            cnt_q  <= ZERO;
            wrap_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end else if (run_i && step_i.dn) begin
          if (cnt_q == ZERO) begin
            cnt_q  <= norel_i ? TOP : rel_q;
            wrap_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
      end
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rel_q;
  assign wrap_o   = wrap_q;

endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MODE_W      = 8,
  parameter int STYLE       = STYLE_SELECT,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);

  localparam int PAD_MODE = CNT_W - MODE_W;
  localparam int PAD_CTRL = CNT_W - 2;

  logic [MODE_W-1:0] mode_q;
  logic              start_q;
  logic              twoph_q;
  logic [CNT_W-1:0]  rd_q;

  logic a_lvl, a_chg, b_lvl, b_chg;
  logic twoph_act, quad_eff;
  logic ld_cnt, ld_rel;
  step_t step;
  logic [CNT_W-1:0] count_w, reload_w;
  logic wrap_w;

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      start_q <= 1'b0;
      twoph_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_MODE) mode_q <= wr_data_i[MODE_W-1:0];
      if (wr_addr_i == ADDR_CTRL) begin
        start_q <= wr_data_i[0];
        twoph_q <= wr_data_i[1];
      end
    end
  end

  assign ld_cnt = wr_en_i && (wr_addr_i == ADDR_COUNT) && !start_q;
  assign ld_rel = wr_en_i && (wr_addr_i == ADDR_COUNT) &&  start_q;

  assign twoph_act = twoph_q && (mode_q[5:0] == MODE_TWOPH_PATTERN);

  generate
    if (STYLE == STYLE_SELECT) begin : g_sel
      assign quad_eff = mode_q[MODE_QUAD_BIT];
    end else if (STYLE == STYLE_QUAD) begin : g_quad
      assign quad_eff = 1'b1;
    end else begin : g_gated
      assign quad_eff = 1'b0;
    end
  endgenerate

  qpc_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .pin_i(phase_a_i), .level_o(a_lvl), .chg_o(a_chg)
  );

  qpc_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .pin_i(phase_b_i), .level_o(b_lvl), .chg_o(b_chg)
  );

  qpc_decode u_decode (
    .a_lvl_i(a_lvl), .b_lvl_i(b_lvl), .a_chg_i(a_chg), .b_chg_i(b_chg),
    .twoph_i(twoph_act), .quad_i(quad_eff), .step_o(step)
  );

  qpc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run_i(start_q), .step_i(step),
    .ld_cnt_i(ld_cnt), .ld_rel_i(ld_rel), .wdata_i(wr_data_i),
    .norel_i(mode_q[MODE_NORELOAD_BIT]),
    .count_o(count_w), .reload_o(reload_w), .wrap_o(wrap_w)
  );

  // registered readback
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr_i)
        ADDR_MODE:   rd_q <= {{PAD_MODE{1'b0}}, mode_q};
        ADDR_CTRL:   rd_q <= {{PAD_CTRL{1'b0}}, twoph_q, start_q};
        ADDR_COUNT:  rd_q <= count_w;
        default:     rd_q <= reload_w;
      endcase
    end
  end

  assign rd_data_o = rd_q;
  assign count_o   = count_w;
  assign wrap_o    = wrap_w;

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_i,
  input logic             wrap_i,
  input logic             start_i,
  input logic             a_chg_i,
  input logic             b_chg_i,
  input logic             twoph_i,
  input logic             quad_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP = '1;

  logic wr_cnt;
  assign wr_cnt = wr_en_i && (wr_addr_i == 2'd2) && !start_i;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !wr_cnt) |=> $stable(count_i)); // R2

  AST_GATED_A_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start_i && twoph_i && !quad_i && a_chg_i && !b_chg_i) |=> $stable(count_i)); // R3

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (start_i && !wr_cnt) |=> (wrap_i || count_i == $past(count_i) ||
                              count_i == $past(count_i) + ONE ||
                              count_i == $past(count_i) - ONE)); // R4

  AST_SAME_CYCLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (start_i && twoph_i && a_chg_i && b_chg_i) |=> $stable(count_i)); // R5

  AST_WRAP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    wrap_i |-> ($past(count_i) == TOP || $past(count_i) == '0)); // R8

endmodule

bind qpc_counter qpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .count_i(count_o), .wrap_i(wrap_o),
  .start_i(start_q), .a_chg_i(a_chg), .b_chg_i(b_chg),
  .twoph_i(twoph_act), .quad_i(quad_eff),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i)
);

// File: tb/sim_qpc_counter.sv
`timescale 1ns/1ps
module sim_qpc_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pa = 1'b0, pb = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd0, cnt0, rd1, cnt1;
  logic        wrap0, wrap1;

  int checks = 0, failures = 0, wraps = 0;
  bit done = 1'b0;

  logic [15:0] q_exp[$];
  bit          q_sel[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  qpc_counter #(.STYLE(2)) u0 (
    .clk(clk), .rst(rst), .phase_a_i(pa), .phase_b_i(pb),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd0), .count_o(cnt0), .wrap_o(wrap0)
  );

  qpc_counter #(.STYLE(0)) u1 (
    .clk(clk), .rst(rst), .phase_a_i(pa), .phase_b_i(pb),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd1), .count_o(cnt1), .wrap_o(wrap1)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the count outputs
  always @(negedge clk) begin
    if (wrap0) wraps++;
    if (q_exp.size() > 0) begin
      logic [15:0] e;
      bit s;
      string t;
      e = q_exp.pop_front();
      s = q_sel.pop_front();
      t = q_tag.pop_front();
      chk(t, s ? cnt1 : cnt0, e);
    end
  end

  task automatic expect_cnt(bit sel, logic [15:0] e, string tag);
    q_exp.push_back(e);
    q_sel.push_back(sel);
    q_tag.push_back(tag);
  endtask

  task automatic move(bit na, bit nb, logic [15:0] e, string tag);
    @(negedge clk);
    pa = na;
    pb = nb;
    repeat (4) @(negedge clk);
    expect_cnt(1'b0, e, tag);
  endtask

  task automatic wreg(logic [1:0] addr, logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(logic [1:0] addr, logic [15:0] exp, string tag);
    @(negedge clk);
    rd_addr = addr;
    @(negedge clk);
    chk(tag, rd0, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", cnt0, 16'h0000);
    chk("R1 wrap", {15'd0, wrap0}, 16'h0000);
    rreg(2'd0, 16'h0000, "R1 mode");
    rreg(2'd1, 16'h0000, "R1 ctrl");
    rreg(2'd3, 16'h0000, "R1 reload");

    // gated style
    wreg(2'd0, 16'h0011);
    wreg(2'd1, 16'h0003);
    rreg(2'd0, 16'h0011, "R11 mode read");
    rreg(2'd1, 16'h0003, "R11 ctrl read");
    move(1, 0, 16'd0, "R3 A rise ignored");
    move(1, 1, 16'd1, "R3 B rise A high");
    move(1, 0, 16'd0, "R3 B fall A high");
    move(1, 1, 16'd1, "R3 B rise again");
    move(0, 1, 16'd1, "R3 A fall ignored");
    move(0, 0, 16'd1, "R3 B fall A low");

    // running count write touches reload only
    wreg(2'd2, 16'h1234);
    repeat (2) @(negedge clk);
    expect_cnt(1'b0, 16'd1, "R10 running write keeps count");
    rreg(2'd3, 16'h1234, "R10 running write reload");

    // four-edge with reload
    wreg(2'd1, 16'h0002);
    wreg(2'd2, 16'd2);
    rreg(2'd3, 16'd2, "R10 stopped write reload");
    rreg(2'd2, 16'd2, "R10 stopped write count");
    wreg(2'd0, 16'h0091);
    wreg(2'd1, 16'h0003);
    move(0, 1, 16'd1, "R4 down 00-01");
    move(1, 1, 16'd0, "R4 down 01-11");
    move(1, 0, 16'd2, "R9 underflow reload");
    chk("R9 wrap strobe", wraps[15:0], 16'd1);
    move(0, 0, 16'd1, "R4 down 10-00");
    move(1, 0, 16'd2, "R4 up 00-10");
    move(1, 1, 16'd3, "R4 up 10-11");
    move(0, 1, 16'd4, "R4 up 11-01");
    move(0, 0, 16'd5, "R4 up 01-00");
    move(1, 1, 16'd5, "R5 both rise");
    move(0, 0, 16'd5, "R5 both fall");

    // no reload
    wreg(2'd1, 16'h0002);
    wreg(2'd2, 16'd0);
    wreg(2'd0, 16'h00D1);
    wreg(2'd1, 16'h0003);
    move(0, 1, 16'hFFFF, "R9 underflow no reload");
    chk("R9 wrap strobe 2", wraps[15:0], 16'd2);
    move(0, 0, 16'h0000, "R8 overflow");
    chk("R8 wrap strobe", wraps[15:0], 16'd3);

    // plain event counting
    wreg(2'd1, 16'h0001);
    move(1, 0, 16'd0, "R6 A ignored");
    move(1, 1, 16'd1, "R6 B rise");
    move(1, 0, 16'd1, "R6 B fall no count");
    move(0, 0, 16'd1, "R6 A fall ignored");
    move(0, 1, 16'd2, "R6 B rise A low");
    move(0, 0, 16'd2, "R6 B fall");
    wreg(2'd0, 16'h00D3);
    wreg(2'd1, 16'h0003);
    move(0, 1, 16'd3, "R6 bad pattern counts plainly");
    move(0, 0, 16'd3, "R6 bad pattern fall");

    // stopped
    wreg(2'd1, 16'h0002);
    wreg(2'd0, 16'h0011);
    move(1, 0, 16'd3, "R2 stopped A");
    move(1, 1, 16'd3, "R2 stopped B rise");
    move(0, 1, 16'd3, "R2 stopped A fall");
    move(0, 0, 16'd3, "R2 stopped B fall");

    // fixed style vs selectable style
    wreg(2'd2, 16'd100);
    wreg(2'd0, 16'h0091);
    wreg(2'd1, 16'h0003);
    move(1, 0, 16'd101, "R7 step1");
    move(1, 1, 16'd102, "R7 step2");
    move(0, 1, 16'd103, "R7 step3");
    move(0, 0, 16'd104, "R7 select four-edge");
    expect_cnt(1'b1, 16'd101, "R7 fixed gated ignores bit7");
    rreg(2'd2, 16'd104, "R11 count read");
    chk("R8 no extra wraps", wraps[15:0], 16'd3);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule